// File: doc/BRIEF.md
# Five-Tap FIR Filter with One Cut-Set Pipeline Stage

This block is a direct-form finite impulse response filter with five signed taps. Each accepted input sample produces one output equal to the sum of the five coefficient-by-sample products over the current sample and the four accepted before it. The output keeps full precision, so it never rounds and never saturates.

The datapath is split into two stages by a single feedforward cut-set. The cut-set crosses exactly two edges. The first is the partial sum formed by the three newest products. The second is the delay-line edge that feeds the two oldest taps. One register is placed on each of these edges. As a result, neither stage is deeper than one multiplier followed by two adders, and every result leaves the block one clock after the unpipelined result would have.

Samples arrive with a qualifying strobe, and idle cycles may appear between them. The five coefficients come in on a static port and are expected to change only while the block is held in reset. The output carries its own strobe. That strobe stays low until five samples have been accepted since reset.

Top module: `fir5_cutset`

## Requirements
- R1: In the cycle after a sample x[n] is accepted (`in_valid` high at a rising edge), `out_sample` equals h0·x[n] + h1·x[n-1] + h2·x[n-2] + h3·x[n-3] + h4·x[n-4]. All terms are signed two's complement. Here x[n-k] means the k-th accepted sample before x[n].
- R2: `out_valid` is high in the cycle right after the rising edge that accepts the fifth sample since reset, and after every later accepted sample.
- R3: `out_valid` stays low for the first four samples accepted after reset.
- R4: Cycles with `in_valid` low do not advance the taps, whatever `in_sample` carries, and `out_valid` is low in the cycle after such a cycle.
- R5: For any inputs, `out_sample` holds the exact result without overflow. With 16-bit operands, five products of −32768 by −32768 give +5·2^30.
- R6: A synchronous active-high `rst` clears the taps, both cut-set registers and the strobe pipeline. After reset, `out_valid` is low and the five-sample fill starts again.
- R7: Coefficient hk sits in `coef_set` bits [16k+15:16k] for the default width. A single nonzero sample A followed by zero samples yields A·h0, A·h1, A·h2, A·h3, A·h4 on the next five outputs, in that order.
- R8: The results do not depend on the spacing of samples. Any pattern of idle cycles between samples gives the same output sequence as back-to-back input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_sample` carries a sample to accept |
| in_sample | input | DATA_W (16) | Signed input sample |
| coef_set | input | 5·COEF_W (80) | Five signed coefficients, h0 in the lowest slice |
| out_valid | output | 1 | High when `out_sample` carries a result |
| out_sample | output | OUT_W (35) | Signed full-precision filter output |

## Verification
The assertions assume that `coef_set` stays constant between resets. They also assume that `in_sample` is only meaningful when `in_valid` is high. The overflow and zero-history properties are stated in terms of the accepted samples alone, not the bus contents on idle cycles. The bench changes coefficients only while reset is held, and it drives random junk on the sample bus during idle cycles so that R4 is tested. Stimulus covers impulses, long random runs (both back-to-back and with random gaps), a reset in mid-fill, and sweeps of full-scale extreme values against a coefficient set with every entry at −32768.

// File: rtl/fir5_pkg.sv
package fir5_pkg;
   // number of filter taps; the cut-set placement below assumes five
   localparam int TAPS    = 5;
   // taps whose products are summed ahead of the cut-set
   localparam int CUT_TAP = 3;
   // growth bits needed to add TAPS full-scale products
   localparam int GUARD_W = $clog2(TAPS);
   // width of the accepted-sample counter
   localparam int FILL_W  = $clog2(TAPS + 1);
endpackage

// File: rtl/fir5_mul.sv
module fir5_mul #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int OUT_W  = 35
) (
   input  logic signed [DATA_W-1:0] x,
   input  logic signed [COEF_W-1:0] h,
   output logic        [OUT_W-1:0]  p
);
   localparam int PROD_W = DATA_W + COEF_W;
   localparam int EXT_W  = OUT_W - PROD_W;

   logic signed [PROD_W-1:0] prod_full;

   assign prod_full = x * h;

   generate
      if (EXT_W > 0) begin : g_ext
         assign p = {{EXT_W{prod_full[PROD_W-1]}}, prod_full};
      end else begin : g_fit
         assign p = prod_full[OUT_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fir5_sum3.sv
module fir5_sum3 #(
   parameter int W = 35
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s
);
   // two chained adders; two's complement needs no sign handling
   logic [W-1:0] ab;

   assign ab = a + b;
   assign s  = ab + c;
endmodule

// File: rtl/fir5_shift.sv
module fir5_shift #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic [W-1:0]              din,
   output logic [DEPTH-1:0][W-1:0]   taps
);
   genvar i;
   generate
      for (i = 0; i < DEPTH; i++) begin : g_stage
         logic [W-1:0] src;
         if (i == 0) begin : g_head
            assign src = din;
         end else begin : g_link
            assign src = taps[i-1];
         end
         always_ff @(posedge clk) begin
            if (rst) begin
               taps[i] <= '0;
            end else if (en) begin
               taps[i] <= src;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/fir5_cutset.sv
module fir5_cutset
   import fir5_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int OUT_W  = DATA_W + COEF_W + GUARD_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [DATA_W-1:0]         in_sample,
   input  logic [TAPS*COEF_W-1:0]    coef_set,
   output logic                      out_valid,
   output logic [OUT_W-1:0]          out_sample
);
   localparam int PRE_DLY  = CUT_TAP - 1;
   localparam int POST_DLY = TAPS - CUT_TAP;
   localparam logic [FILL_W-1:0] PRIME_AT = FILL_W'(TAPS - 1);
   localparam logic [FILL_W-1:0] FULL_AT  = FILL_W'(TAPS);

   // elaboration-time parameter checks
   generate
      if (DATA_W < 2 || COEF_W < 2) begin : g_bad_operand
         $error("fir5_cutset: operand widths must be at least 2");
      end
      if (OUT_W < DATA_W + COEF_W + GUARD_W) begin : g_bad_out
         $error("fir5_cutset: OUT_W too narrow for full precision");
      end
      if (CUT_TAP != 3 || TAPS != 5) begin : g_bad_cut
         $error("fir5_cutset: two three-input sums require TAPS=5, CUT_TAP=3");
      end
   endgenerate

   logic [PRE_DLY-1:0][DATA_W-1:0]  pre_line;
   logic [POST_DLY-1:0][DATA_W-1:0] post_line;
   logic [TAPS-1:0][DATA_W-1:0]     tap_x;
   logic [TAPS-1:0][OUT_W-1:0]      prod;
   logic [OUT_W-1:0]                head_sum;
   logic [OUT_W-1:0]                tail_sum;

   // cut-set registers: partial sum and delay-line edge
   logic [OUT_W-1:0]                cut_sum_q;
   logic [DATA_W-1:0]               cut_tap_q;
   // strobe pipeline: raw advance and primed output strobe
   logic                            cut_adv_q;
   logic                            cut_vld_q;
   logic [FILL_W-1:0]               fill_cnt;

   // stage one delay line: x[n-1], x[n-2]
   fir5_shift #(.W(DATA_W), .DEPTH(PRE_DLY)) u_pre_line (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .din  (in_sample),
      .taps (pre_line)
   );

   // stage two delay line, fed across the cut: x[n-3], x[n-4]
   fir5_shift #(.W(DATA_W), .DEPTH(POST_DLY)) u_post_line (
      .clk  (clk),
      .rst  (rst),
      .en   (cut_adv_q),
      .din  (cut_tap_q),
      .taps (post_line)
   );

   assign tap_x[0] = in_sample;

   genvar k;
   generate
      for (k = 0; k < PRE_DLY; k++) begin : g_pre_tap
         assign tap_x[k+1] = pre_line[k];
      end
      for (k = 0; k < POST_DLY; k++) begin : g_post_tap
         assign tap_x[CUT_TAP+k] = post_line[k];
      end
      for (k = 0; k < TAPS; k++) begin : g_mul
         fir5_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W), .OUT_W(OUT_W)) u_mul (
            .x (tap_x[k]),
            .h (coef_set[k*COEF_W +: COEF_W]),
            .p (prod[k])
         );
      end
   endgenerate

   // stage one: multiplier plus two adders
   fir5_sum3 #(.W(OUT_W)) u_head (
      .a (prod[0]),
      .b (prod[1]),
      .c (prod[2]),
      .s (head_sum)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cut_sum_q <= '0;
         cut_tap_q <= '0;
         cut_adv_q <= 1'b0;
         cut_vld_q <= 1'b0;
         fill_cnt  <= '0;
      end else begin
         cut_sum_q <= head_sum;
         cut_tap_q <= pre_line[PRE_DLY-1];
         cut_adv_q <= in_valid;
         cut_vld_q <= in_valid && (fill_cnt >= PRIME_AT);
         if (in_valid && (fill_cnt != FULL_AT)) begin
            fill_cnt <= fill_cnt + 1'b1;
         end
      end
   end

   // stage two: multiplier plus two adders
   fir5_sum3 #(.W(OUT_W)) u_tail (
      .a (cut_sum_q),
      .b (prod[3]),
      .c (prod[4]),
      .s (tail_sum)
   );

   assign out_sample = tail_sum;
   assign out_valid  = cut_vld_q;
endmodule

// File: rtl/fir5_cutset_chk.sv
module fir5_cutset_chk
   import fir5_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int OUT_W  = DATA_W + COEF_W + GUARD_W
) (
   input logic                   clk,
   input logic                   rst,
   input logic                   in_valid,
   input logic [DATA_W-1:0]      in_sample,
   input logic                   out_valid,
   input logic [OUT_W-1:0]       out_sample
);
   localparam longint LIM = longint'(TAPS) << (DATA_W + COEF_W - 2);

   logic [FILL_W-1:0]       seen_cnt;
   logic [TAPS-1:0]         nz_hist;
   logic signed [OUT_W-1:0] y_s;
   longint                  y_l;

   assign y_s = out_sample;
   assign y_l = longint'(y_s);

   always_ff @(posedge clk) begin
      if (rst) begin
         seen_cnt <= '0;
         nz_hist  <= '0;
      end else if (in_valid) begin
         if (seen_cnt != FILL_W'(TAPS)) seen_cnt <= seen_cnt + 1'b1;
         nz_hist <= {nz_hist[TAPS-2:0], (in_sample != '0)};
      end
   end

   assert_zero_history_R1: assert property (@(posedge clk) disable iff (rst)
      (out_valid && nz_hist == '0) |-> (out_sample == '0));

   assert_primed_strobe_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && seen_cnt >= FILL_W'(TAPS - 1)) |=> out_valid);

   assert_fill_quiet_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (seen_cnt == FILL_W'(TAPS)));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (y_l <= LIM && y_l >= -LIM));

   assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !out_valid);
endmodule

bind fir5_cutset fir5_cutset_chk #(
   .DATA_W (DATA_W),
   .COEF_W (COEF_W),
   .OUT_W  (OUT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .in_sample  (in_sample),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/fir5_cutset_tb_top.sv
`timescale 1ns/1ps
module fir5_cutset_tb_top;
   localparam int DW = 16;
   localparam int CW = 16;
   localparam int OW = 35;
   localparam int NT = 5;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [DW-1:0]     in_sample = '0;
   logic [NT*CW-1:0]  coef_set = '0;
   logic              out_valid;
   logic [OW-1:0]     out_sample;

   int     n_checks = 0;
   int     n_fail   = 0;
   bit     done     = 1'b0;
   int     coef [NT];
   longint hist [NT];
   int     accepted = 0;

   always #4 clk = ~clk;

   fir5_cutset dut_i (
      .clk        (clk),
      .rst        (rst),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .coef_set   (coef_set),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: out_valid actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic check_val(input string tag, input longint exp);
      logic signed [OW-1:0] ys;
      ys = out_sample;
      n_checks++;
      if (longint'(ys) !== exp) begin
         n_fail++;
         $display("FAIL %s: out_sample actual %0d expected %0d", tag, longint'(ys), exp);
      end
   endtask

   task automatic load_coefs(input int c0, input int c1, input int c2, input int c3, input int c4);
      coef[0] = c0; coef[1] = c1; coef[2] = c2; coef[3] = c3; coef[4] = c4;
      for (int k = 0; k < NT; k++) coef_set[k*CW +: CW] = CW'(coef[k]);
   endtask

   // reset with model cleared; called at a falling edge
   task automatic do_reset();
      in_valid = 1'b0;
      rst = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rst = 1'b0;
      for (int k = 0; k < NT; k++) hist[k] = 0;
      accepted = 0;
      @(posedge clk); @(negedge clk);
      check_bit("R6 after reset", out_valid, 1'b0);
   endtask

   task automatic send(input int s, input string tag);
      longint exp;
      logic signed [DW-1:0] sv;
      sv = DW'(s);
      in_sample = sv;
      in_valid  = 1'b1;
      for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(sv);
      accepted++;
      exp = 0;
      for (int k = 0; k < NT; k++) exp += longint'(coef[k]) * hist[k];
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      if (accepted < NT) begin
         check_bit({tag, " R3 fill"}, out_valid, 1'b0);
      end else begin
         check_bit({tag, " R2 strobe"}, out_valid, 1'b1);
         check_val(tag, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         in_valid  = 1'b0;
         in_sample = DW'($urandom);
         @(posedge clk); @(negedge clk);
         check_bit("R4 idle", out_valid, 1'b0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      load_coefs(3, -5, 7, -11, 13);
      @(negedge clk);
      do_reset();

      // R7 impulse after fill
      for (int i = 0; i < 4; i++) send(0, "R7 lead");
      send(1, "R7 h0");
      send(0, "R7 h1");
      send(0, "R7 h2");
      send(0, "R7 h3");
      send(0, "R7 h4");
      send(-32768, "R7 big h0");
      for (int i = 0; i < 4; i++) send(0, "R7 big tail");

      // R1 back-to-back random
      for (int i = 0; i < 200; i++) send(int'($urandom & 32'hFFFF), "R1 random");

      // R8 and R4 gapped random
      for (int i = 0; i < 150; i++) begin
         idle(int'($urandom_range(0, 3)));
         send(int'($urandom & 32'hFFFF), "R8 gapped");
      end

      // R6 reset during fill, then fill starts over
      do_reset();
      send(100, "R6 pre");
      send(-200, "R6 pre");
      do_reset();
      for (int i = 0; i < 4; i++) send(int'($urandom & 32'hFFFF), "R6 refill");
      send(int'($urandom & 32'hFFFF), "R6 first");

      // R5 extremes with full-scale coefficients
      load_coefs(-32768, -32768, -32768, -32768, -32768);
      do_reset();
      for (int i = 0; i < 5; i++) send(-32768, "R5 max pos");
      for (int i = 0; i < 5; i++) send(32767, "R5 max neg");
      for (int p = 0; p < 32; p++) begin
         for (int b = 0; b < NT; b++) send((p >> b) & 1 ? 32767 : -32768, "R5 sweep");
      end

      // R1 mixed-sign coefficient set with gaps
      load_coefs(32767, -1, 0, -32768, 12345);
      do_reset();
      for (int i = 0; i < 100; i++) begin
         idle(int'($urandom_range(0, 1)));
         send(int'($urandom & 32'hFFFF), "R1 mixed");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule